// File: doc/BRIEF.md
# Master-Mode Audio Clock Generator

This block derives the two clocks of a serial audio output port, the bit clock and the frame (left/right) clock, from a master clock. A 4-bit ratio code sets how many master-clock cycles make up one frame. The supported ratios are 64, 96, 128, 192, 256, 384, 512, 768 and 1024, so some of them are not powers of two. A one-bit speed select picks how many bit clocks make up one frame. When the ratio is a power of two, a frame holds 64 or 128 bit clocks. For the ratios that carry a factor of three, it holds 48 or 96. The master-clock cycles per bit clock are then always 1, 2, 4, 8 or 16.

Software writes the configuration inputs while the port is held in power-down. The block captures them on every cycle in which power-down is high and holds them once power-down falls. When the captured configuration selects master mode and is legal, the block drives both clocks and raises their output-enable controls. In slave mode the enables stay low, so the pads can be left to external clocks. An illegal combination raises a flag and keeps both clocks low.

Top module: `aclk_master_gen`

## Requirements
- R1: The frame clock period in master-clock cycles follows the captured ratio code c. For even c it is 64·2^(c/2). For odd c it is 96·2^((c-1)/2). Codes 0 to 8 therefore give 64, 96, 128, 192, 256, 384, 512, 768 and 1024.
- R2: With bclk_fast=0, a frame holds 64 bit clocks for even codes and 48 for odd codes. With bclk_fast=1, it holds 128 and 96.
- R3: The bit clock has a period of D = ratio/bits master cycles, is low for the first D/2 of them and high for the last D/2. When D is 1, the bit clock is the inverted master clock.
- R4: The frame clock is low for the first half of each frame and high for the second half. Every frame-clock change coincides with a falling bit-clock edge. The first frame after start begins with both clocks low.
- R5: Code 0 with bclk_fast=1, and every code from 9 to 15, set cfg_invalid=1 and hold both clocks low. All other settings leave cfg_invalid=0.
- R6: A captured master_sel=0 (slave) forces bclk_oe=0, fclk_oe=0 and both clocks low. A captured master_sel=1 sets both enables to 1.
- R7: Inputs are captured on each rising edge at which pwr_dn=1 and are visible one cycle later. Changes made while pwr_dn=0 have no effect on the clocks, the enables or cfg_invalid.
- R8: One cycle after pwr_dn is sampled high, both clocks are low. After release, clock generation restarts at the start of a frame.
- R9: Reset clears the captured configuration to all zeros. This gives slave mode with low enables, low clocks and cfg_invalid=0 until a configuration is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; configuration is captured while high |
| master_sel | input | 1 | 1 = block drives the clocks, 0 = slave |
| bclk_fast | input | 1 | Bit-clock speed select (doubles bits per frame) |
| ratio_code | input | 4 | Master cycles per frame code |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| bclk_oe | output | 1 | Output enable for the bit clock pad |
| fclk_oe | output | 1 | Output enable for the frame clock pad |
| cfg_invalid | output | 1 | Captured configuration is illegal |

## Verification
The bench sweeps all 32 combinations of ratio code and speed select in master mode and samples both clocks on every master cycle over two frames. It compares them with levels computed from the cycle index, the ratio and the divisor. This separates the power-of-two family from the ×3 family, and it separates the divide-by-one pass-through from the true dividers. Counting the falling bit-clock edges within one frame checks the bits-per-frame choice. The illegal codes, slave mode, and changes made mid-run without power-down are each run as their own pattern. These show that the flag, the enables and the quiet outputs follow only the configuration captured during power-down.

// File: rtl/aclk_pkg.sv
`timescale 1ns/1ps
package aclk_pkg;
   localparam int CODE_W = 4;

   typedef struct packed {
      logic              master;
      logic              fast;
      logic [CODE_W-1:0] code;
   } aclk_ctl_t;
endpackage

// File: rtl/aclk_cfg_hold.sv
`timescale 1ns/1ps
module aclk_cfg_hold
   import aclk_pkg::*;
(
   input  logic      mclk,
   input  logic      rst_n,
   input  logic      pwr_dn,
   input  aclk_ctl_t ctl_in,
   output aclk_ctl_t ctl_q
);
   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (pwr_dn) begin
         ctl_q <= ctl_in;
      end
   end
endmodule

// File: rtl/aclk_ratio_decode.sv
`timescale 1ns/1ps
module aclk_ratio_decode
   import aclk_pkg::*;
#(
   parameter int MAX_CODE     = 8,
   parameter int BASE_LOG2    = 6,
   parameter bit ALLOW_DIRECT = 1'b1,
   parameter int CNT_W        = 10,
   parameter int LOG_W        = 3
) (
   input  aclk_ctl_t        ctl,
   output logic             invalid,
   output logic [LOG_W-1:0] div_log2,
   output logic [CNT_W-1:0] ratio_m1,
   output logic [CNT_W-1:0] half
);
   int   code_i;
   int   k_i;
   int   ratio_i;
   logic direct_bad;

   // divisor exponent and frame length from the code family
   always_comb begin
      code_i = int'(ctl.code);
      if (!ctl.code[0]) begin
         k_i     = code_i / 2 - int'(ctl.fast);
         ratio_i = 1 << (BASE_LOG2 + code_i / 2);
      end else begin
         k_i     = 1 + (code_i - 1) / 2 - int'(ctl.fast);
         ratio_i = 3 << (BASE_LOG2 - 1 + (code_i - 1) / 2);
      end
   end

   generate
      if (ALLOW_DIRECT) begin : g_direct_ok
         assign direct_bad = 1'b0;
      end else begin : g_direct_bad
         assign direct_bad = (k_i == 0);
      end
   endgenerate

   always_comb begin
      invalid = (code_i > MAX_CODE) || (k_i < 0) || direct_bad;
      if (invalid) begin
         div_log2 = '0;
         ratio_m1 = '0;
         half     = '0;
      end else begin
         div_log2 = LOG_W'(k_i);
         ratio_m1 = CNT_W'(ratio_i - 1);
         half     = CNT_W'(ratio_i / 2);
      end
   end
endmodule

// File: rtl/aclk_phase_gen.sv
`timescale 1ns/1ps
module aclk_phase_gen #(
   parameter int CNT_W        = 10,
   parameter int LOG_W        = 3,
   parameter bit ALLOW_DIRECT = 1'b1
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [LOG_W-1:0] div_log2,
   input  logic [CNT_W-1:0] ratio_m1,
   input  logic [CNT_W-1:0] half,
   output logic             bclk,
   output logic             fclk
);
   logic             run_q;
   logic             bclk_q;
   logic             fclk_q;
   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] pos_n;
   logic [CNT_W-1:0] bit_mask;
   logic             bclk_n;

   always_comb begin
      pos_n    = (pos_q == ratio_m1) ? '0 : pos_q + 1'b1;
      bit_mask = CNT_W'(1) << (div_log2 - LOG_W'(1));
      bclk_n   = (div_log2 != '0) && ((pos_n & bit_mask) != '0);
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pos_q  <= '0;
         bclk_q <= 1'b0;
         fclk_q <= 1'b0;
      end else begin
         run_q <= run_req;
         if (!run_q) begin
            pos_q  <= '0;
            bclk_q <= 1'b0;
            fclk_q <= 1'b0;
         end else begin
            pos_q  <= pos_n;
            bclk_q <= bclk_n;
            fclk_q <= (pos_n >= half);
         end
      end
   end

   generate
      if (ALLOW_DIRECT) begin : g_pass
         assign bclk = run_q & ((div_log2 == '0) ? ~mclk : bclk_q);
      end else begin : g_div_only
         assign bclk = run_q & bclk_q;
      end
   endgenerate

   assign fclk = run_q & fclk_q;
endmodule

// File: rtl/aclk_master_gen.sv
`timescale 1ns/1ps
module aclk_master_gen
   import aclk_pkg::*;
#(
   parameter int MAX_CODE     = 8,
   parameter int BASE_LOG2    = 6,
   parameter bit ALLOW_DIRECT = 1'b1
) (
   input  logic              mclk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              master_sel,
   input  logic              bclk_fast,
   input  logic [CODE_W-1:0] ratio_code,
   output logic              bclk_o,
   output logic              fclk_o,
   output logic              bclk_oe,
   output logic              fclk_oe,
   output logic              cfg_invalid
);
   localparam int CNT_W = BASE_LOG2 + MAX_CODE / 2;
   localparam int LOG_W = $clog2(MAX_CODE / 2 + 2);

   generate
      if (MAX_CODE % 2 != 0) begin : g_chk_even
         $error("MAX_CODE must be even");
      end
      if (MAX_CODE >= (1 << CODE_W)) begin : g_chk_code
         $error("MAX_CODE does not fit the code width");
      end
      if (BASE_LOG2 < 2) begin : g_chk_base
         $error("BASE_LOG2 must be at least 2");
      end
   endgenerate

   aclk_ctl_t        ctl_in;
   aclk_ctl_t        ctl_q;
   logic [LOG_W-1:0] div_log2;
   logic [CNT_W-1:0] ratio_m1;
   logic [CNT_W-1:0] half;
   logic             run_req;

   assign ctl_in = '{master: master_sel, fast: bclk_fast, code: ratio_code};

   aclk_cfg_hold u_hold (
      .mclk   (mclk),
      .rst_n  (rst_n),
      .pwr_dn (pwr_dn),
      .ctl_in (ctl_in),
      .ctl_q  (ctl_q)
   );

   aclk_ratio_decode #(
      .MAX_CODE     (MAX_CODE),
      .BASE_LOG2    (BASE_LOG2),
      .ALLOW_DIRECT (ALLOW_DIRECT),
      .CNT_W        (CNT_W),
      .LOG_W        (LOG_W)
   ) u_dec (
      .ctl      (ctl_q),
      .invalid  (cfg_invalid),
      .div_log2 (div_log2),
      .ratio_m1 (ratio_m1),
      .half     (half)
   );

   assign run_req = ctl_q.master & ~cfg_invalid & ~pwr_dn;

   aclk_phase_gen #(
      .CNT_W        (CNT_W),
      .LOG_W        (LOG_W),
      .ALLOW_DIRECT (ALLOW_DIRECT)
   ) u_gen (
      .mclk     (mclk),
      .rst_n    (rst_n),
      .run_req  (run_req),
      .div_log2 (div_log2),
      .ratio_m1 (ratio_m1),
      .half     (half),
      .bclk     (bclk_o),
      .fclk     (fclk_o)
   );

   assign bclk_oe = ctl_q.master;
   assign fclk_oe = ctl_q.master;
endmodule

// File: rtl/aclk_master_gen_chk.sv
`timescale 1ns/1ps
module aclk_master_gen_chk #(
   parameter int LOG_W = 3
) (
   input logic             mclk,
   input logic             rst_n,
   input logic             pwr_dn,
   input logic             bclk_o,
   input logic             fclk_o,
   input logic             bclk_oe,
   input logic             fclk_oe,
   input logic             cfg_invalid,
   input logic [LOG_W-1:0] div_log2
);
   assert_invalid_quiet_R5: assert property (@(posedge mclk) disable iff (!rst_n)
      cfg_invalid |-> (!bclk_o && !fclk_o));

   assert_slave_quiet_R6: assert property (@(posedge mclk) disable iff (!rst_n)
      !bclk_oe |-> (!fclk_oe && !bclk_o && !fclk_o));

   assert_hold_cfg_R7: assert property (@(posedge mclk) disable iff (!rst_n)
      (!pwr_dn && !$past(pwr_dn)) |-> ($stable(cfg_invalid) && $stable(bclk_oe)));

   assert_pd_stop_R8: assert property (@(posedge mclk) disable iff (!rst_n)
      pwr_dn |=> (!bclk_o && !fclk_o));

   assert_fclk_on_fall_R4: assert property (@(posedge mclk) disable iff (!rst_n)
      (!$past(pwr_dn) && (div_log2 != '0) && $changed(fclk_o)) |-> $fell(bclk_o));
endmodule

bind aclk_master_gen aclk_master_gen_chk #(.LOG_W(LOG_W)) u_chk (
   .mclk        (mclk),
   .rst_n       (rst_n),
   .pwr_dn      (pwr_dn),
   .bclk_o      (bclk_o),
   .fclk_o      (fclk_o),
   .bclk_oe     (bclk_oe),
   .fclk_oe     (fclk_oe),
   .cfg_invalid (cfg_invalid),
   .div_log2    (div_log2)
);

// File: tb/aclk_master_gen_tb.sv
`timescale 1ns/1ps
module aclk_master_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic       mclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_dn = 1'b0;
   logic       master_sel = 1'b1;
   logic       bclk_fast = 1'b0;
   logic [3:0] ratio_code = 4'd3;
   logic       bclk_o, fclk_o, bclk_oe, fclk_oe, cfg_invalid;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) mclk = ~mclk;

   aclk_master_gen u_dut (
      .mclk        (mclk),
      .rst_n       (rst_n),
      .pwr_dn      (pwr_dn),
      .master_sel  (master_sel),
      .bclk_fast   (bclk_fast),
      .ratio_code  (ratio_code),
      .bclk_o      (bclk_o),
      .fclk_o      (fclk_o),
      .bclk_oe     (bclk_oe),
      .fclk_oe     (fclk_oe),
      .cfg_invalid (cfg_invalid)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int frame_len(input int code);
      return (code % 2 == 0) ? (64 << (code / 2)) : (96 << ((code - 1) / 2));
   endfunction

   function automatic int frame_bits(input int code, input int sel);
      if (code % 2 == 0) return (sel != 0) ? 128 : 64;
      return (sel != 0) ? 96 : 48;
   endfunction

   function automatic bit exp_bclk(input int p, input int dv);
      if (dv == 1) return 1'b1;   // sampled just after falling master edge
      return ((p % dv) >= dv / 2);
   endfunction

   task automatic run_cfg(input int code, input int sel, input int master);
      bit exp_inv, running;
      int ratio, bits, dv, n, bad_b, bad_f, bad_q, falls, fa, fe;
      logic prev;
      exp_inv = (code > 8) || (code == 0 && sel == 1);
      ratio = frame_len(code);
      bits  = frame_bits(code, sel);
      dv    = exp_inv ? 1 : ratio / bits;
      @(negedge mclk);
      pwr_dn = 1'b1; master_sel = master[0]; bclk_fast = sel[0]; ratio_code = code[3:0];
      repeat (3) @(negedge mclk);
      #1;
      check(cfg_invalid == exp_inv, "R5", $sformatf("flag code=%0d sel=%0d", code, sel),
            int'(cfg_invalid), int'(exp_inv));
      check(bclk_oe == master[0] && fclk_oe == master[0], "R6", "enables",
            int'(bclk_oe), master);
      @(negedge mclk);
      pwr_dn = 1'b0;
      @(posedge mclk);
      running = (master != 0) && !exp_inv;
      n = running ? 2 * ratio : 64;
      bad_b = 0; bad_f = 0; bad_q = 0; falls = 0; prev = 1'b0; fa = 0; fe = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge mclk);
         #1;
         if (running) begin
            if (bclk_o != exp_bclk(i % ratio, dv)) begin
               if (bad_b == 0) begin fa = int'(bclk_o); fe = int'(exp_bclk(i % ratio, dv)); end
               bad_b++;
            end
            if (fclk_o != ((i % ratio) >= ratio / 2)) bad_f++;
            if (i >= 1 && i <= ratio && prev && !bclk_o) falls++;
            prev = bclk_o;
         end else if (bclk_o || fclk_o) begin
            bad_q++;
         end
      end
      if (running) begin
         check(bad_b == 0, "R3", $sformatf("bit clock code=%0d sel=%0d first", code, sel), fa, fe);
         check(bad_f == 0, "R1", $sformatf("frame period code=%0d sel=%0d mismatches", code, sel),
               bad_f, 0);
         if (dv > 1)
            check(falls == bits, "R2", $sformatf("bits per frame code=%0d sel=%0d", code, sel),
                  falls, bits);
      end else begin
         check(bad_q == 0, exp_inv ? "R5" : "R6",
               $sformatf("quiet clocks code=%0d sel=%0d", code, sel), bad_q, 0);
      end
   endtask

   initial begin
      int bad;
      int e_b;
      repeat (4) @(negedge mclk);
      rst_n = 1'b1;
      // R9: nothing captured yet (pwr_dn low), so slave defaults apply
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge mclk);
         #1;
         if (bclk_o || fclk_o || bclk_oe || fclk_oe || cfg_invalid) bad++;
      end
      check(bad == 0, "R9", "reset state deviations", bad, 0);

      for (int code = 0; code < 16; code++)
         for (int sel = 0; sel < 2; sel++)
            run_cfg(code, sel, 1);

      run_cfg(4, 0, 0);   // R6 slave
      run_cfg(2, 1, 0);

      // R7: mid-run changes without power-down are ignored
      @(negedge mclk);
      pwr_dn = 1'b1; master_sel = 1'b1; bclk_fast = 1'b0; ratio_code = 4'd4;
      repeat (3) @(negedge mclk);
      pwr_dn = 1'b0;
      @(posedge mclk);
      bad = 0;
      for (int i = 0; i < 768; i++) begin
         @(negedge mclk);
         #1;
         e_b = int'(((i % 256) % 4) >= 2);
         if (int'(bclk_o) != e_b || fclk_o != ((i % 256) >= 128) ||
             !bclk_oe || cfg_invalid) bad++;
         if (i == 100) begin
            ratio_code = 4'd0; bclk_fast = 1'b1; master_sel = 1'b0;
         end
      end
      check(bad == 0, "R7", "outputs after unlatched change deviations", bad, 0);

      // R8: power-down stops the clocks one cycle later; R7 capture follows
      @(negedge mclk);
      pwr_dn = 1'b1;
      @(negedge mclk);
      #1;
      check(!bclk_o && !fclk_o, "R8", "clocks after power-down",
            int'(bclk_o) + int'(fclk_o), 0);
      check(cfg_invalid && !bclk_oe, "R7", "capture during power-down",
            int'(cfg_invalid), 1);
      @(negedge mclk);
      pwr_dn = 1'b0;
      run_cfg(6, 1, 1);   // R8 restart from frame start after release

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge mclk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule